// File: doc/BRIEF.md
# Four-Bit Indirect-Addressed Host Register Port

This block connects a slow host bus to a handful of per-line control and status words in a four-line power-feed controller. A host sees two locations through a single address line. Location 0 is a direct word that holds a 3-bit pointer and a flag bit. Location 1 is a window whose meaning depends on that pointer. Reading it returns one of several per-line status groups, or the line-enable word. Writing it always loads the line-enable word, whatever the pointer holds.

The host strobes are asynchronous to the system clock. Every bus input passes through a reset-initialised synchroniser chain of `SYNC_STAGES` flops. The address is held in a latch that is transparent while the address-latch-enable input is high and that freezes when the input falls. A multiplexed bus pulses that input. A non-multiplexed bus ties it high. A write is staged while its strobes are active and is committed when the write strobe or the chip select is released, whichever happens first. The data bus is split into an input, an output and an output-enable for the pad ring. The status detectors and the driver control sit outside this block.

Top module: `nib_ind_port`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `line_en_o` is 0000, `irq_en_o` is 0 and `dat_oe` is 0. The pointer and the latched address bit are also cleared to 0.
- R2: While `ale` is high, the effective address follows `a0`. After `ale` falls, the value held at the fall is used even if `a0` changes.
- R3: With `ale` held high, reads and writes use `a0` directly (non-multiplexed operation).
- R4: A write to address 0 loads data bits 2..0 into the pointer and data bit 3 into `irq_en_o`.
- R5: A read of address 0 returns the pointer on bits 2..0 and the `hot_i` shutdown flag on bit 3.
- R6: A write to address 1 loads all four data bits into `line_en_o`, whatever the pointer value.
- R7: A read of address 1 returns the group selected by the pointer: 000 `lowv_i`, 001 `open_i`, 010 `ovld_i`, 011 `swon_i`, 110 `line_en_o`, 111 `therm_i`.
- R8: A read of address 1 with pointer code 100 or 101 returns 0000.
- R9: `dat_oe` is high only while the synchronised chip select and read strobe are both low and write is high. It rises `SYNC_STAGES` clock edges after the pins assert. `dat_o` is 0000 whenever `dat_oe` is low.
- R10: A staged write updates its register on the third clock edge after the write strobe or chip select is released (with `SYNC_STAGES` = 2). The data used is the value present while the strobes were active.
- R11: When chip select, read and write are all low together, nothing is written and the bus is not driven.
- R12: In every group, bit n belongs to line n, and bit 0 is the least significant bit of the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ale | input | 1 | Address latch enable; the latch is transparent while high |
| a0 | input | 1 | Address line: 0 direct word, 1 indirect window |
| dat_i | input | NLINES | Data from the host bus |
| dat_o | output | NLINES | Data to the host bus |
| dat_oe | output | 1 | Bus drive enable for the pad |
| lowv_i | input | NLINES | Low-voltage group, one bit per line |
| open_i | input | NLINES | Open-loop group |
| ovld_i | input | NLINES | Current-overload group |
| swon_i | input | NLINES | Switch-state group |
| therm_i | input | NLINES | Thermal-overload group |
| hot_i | input | 1 | Global shutdown flag, read at address 0 bit 3 |
| line_en_o | output | NLINES | Line-enable word |
| irq_en_o | output | 1 | Interrupt-enable bit |

## Verification
Accesses are tried in three forms: with the address-latch-enable input pulsed and `a0` deliberately flipped after the latch closes, with that input tied high, and with the access ended first by the write strobe and then by the chip select. Comparing these forms separates a latch that holds its value from one that only tracks the pin, and shows that the commit point follows whichever strobe is released first. All eight pointer codes are read while each status group carries a distinct pattern. This exposes a swapped group, a leaking reserved code or a reversed bit order. Cycle-exact probes around strobe edges, a dual-strobe access, a read with chip select high and a mid-run reset each pin down one timing or no-access rule.

// File: rtl/nip_pkg.sv
package nip_pkg;

    // Width of the indirect pointer held in the direct word.
    localparam int PTR_W = 3;

    // Pointer codes for the indirect window. The codes are decoded by
    // host software, so their values are fixed.
    typedef enum logic [PTR_W-1:0] {
        SEL_LOWV  = 3'd0,
        SEL_OPEN  = 3'd1,
        SEL_OVLD  = 3'd2,
        SEL_SWST  = 3'd3,
        SEL_RSV4  = 3'd4,
        SEL_RSV5  = 3'd5,
        SEL_LINE  = 3'd6,
        SEL_THERM = 3'd7
    } grp_sel_e;

endpackage

// File: rtl/nip_sync.sv
module nip_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/nip_regs.sv
module nip_regs
    import nip_pkg::*;
#(
    parameter int NL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_s,
    input  logic             rd_s,
    input  logic             wr_s,
    input  logic             ale_s,
    input  logic             a0_s,
    input  logic [NL-1:0]    dat_s,
    output logic [PTR_W-1:0] ptr_o,
    output logic             irq_en_o,
    output logic [NL-1:0]    ler_o,
    output logic             addr_eff_o,
    output logic             addr_q_o
);

    localparam int FLAG_BIT = NL - 1;

    typedef struct packed {
        logic             addr;
        logic [PTR_W-1:0] ptr;
        logic             irq_en;
        logic [NL-1:0]    ler;
        logic             pend;
        logic             padr;
        logic [NL-1:0]    pdat;
    } st_t;

    st_t  st_d, st_q;
    logic addr_eff;
    logic wr_now;

    always_comb begin
        st_d     = st_q;
        addr_eff = ale_s ? a0_s : st_q.addr;
        wr_now   = !cs_s && !wr_s && rd_s;

        // Transparent address latch, frozen while ale is low.
        if (ale_s) begin
            st_d.addr = a0_s;
        end

        // Commit the staged write once the access has ended.
        if (st_q.pend && !wr_now) begin
            if (st_q.padr) begin
                st_d.ler = st_q.pdat;
            end else begin
                st_d.ptr    = st_q.pdat[PTR_W-1:0];
                st_d.irq_en = st_q.pdat[FLAG_BIT];
            end
        end

        // Stage the address and data while the write is active.
        st_d.pend = wr_now;
        if (wr_now) begin
            st_d.padr = addr_eff;
            st_d.pdat = dat_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o      = st_q.ptr;
    assign irq_en_o   = st_q.irq_en;
    assign ler_o      = st_q.ler;
    assign addr_eff_o = addr_eff;
    assign addr_q_o   = st_q.addr;

endmodule

// File: rtl/nip_rdmux.sv
module nip_rdmux
    import nip_pkg::*;
#(
    parameter int NL = 4
) (
    input  logic             cs_s,
    input  logic             rd_s,
    input  logic             wr_s,
    input  logic             addr_eff,
    input  logic [PTR_W-1:0] ptr,
    input  logic             hot,
    input  logic [NL-1:0]    lowv,
    input  logic [NL-1:0]    open_l,
    input  logic [NL-1:0]    ovld,
    input  logic [NL-1:0]    swon,
    input  logic [NL-1:0]    therm,
    input  logic [NL-1:0]    ler,
    output logic [NL-1:0]    dat_o,
    output logic             dat_oe
);

    logic          rd_go;
    logic [NL-1:0] dir_w;
    logic [NL-1:0] ind_w;

    always_comb begin
        rd_go = !cs_s && !rd_s && wr_s;

        dir_w              = '0;
        dir_w[PTR_W-1:0]   = ptr;
        dir_w[NL-1]        = hot;

        case (grp_sel_e'(ptr))
            SEL_LOWV:  ind_w = lowv;
            SEL_OPEN:  ind_w = open_l;
            SEL_OVLD:  ind_w = ovld;
            SEL_SWST:  ind_w = swon;
            SEL_LINE:  ind_w = ler;
            SEL_THERM: ind_w = therm;
            default:   ind_w = '0;
        endcase

        dat_oe = rd_go;
        dat_o  = rd_go ? (addr_eff ? ind_w : dir_w) : '0;
    end

endmodule

// File: rtl/nib_ind_port.sv
module nib_ind_port
    import nip_pkg::*;
#(
    parameter int NLINES      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              ale,
    input  logic              a0,
    input  logic [NLINES-1:0] dat_i,
    output logic [NLINES-1:0] dat_o,
    output logic              dat_oe,
    input  logic [NLINES-1:0] lowv_i,
    input  logic [NLINES-1:0] open_i,
    input  logic [NLINES-1:0] ovld_i,
    input  logic [NLINES-1:0] swon_i,
    input  logic [NLINES-1:0] therm_i,
    input  logic              hot_i,
    output logic [NLINES-1:0] line_en_o,
    output logic              irq_en_o
);

    localparam int                 SW      = 5 + NLINES;
    localparam logic [SW-1:0]      PIN_IDL = {3'b111, 2'b00, {NLINES{1'b0}}};

    logic [SW-1:0]      pin_raw, pin_s;
    logic               cs_s, rd_s, wr_s, ale_s, a0_s;
    logic [NLINES-1:0]  dat_s;
    logic [PTR_W-1:0]   ptr;
    logic [NLINES-1:0]  ler;
    logic               addr_eff;
    logic               addr_q;

    assign pin_raw = {cs_n, rd_n, wr_n, ale, a0, dat_i};
    assign {cs_s, rd_s, wr_s, ale_s, a0_s, dat_s} = pin_s;

    nip_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDL)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    nip_regs #(.NL(NLINES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cs_s       (cs_s),
        .rd_s       (rd_s),
        .wr_s       (wr_s),
        .ale_s      (ale_s),
        .a0_s       (a0_s),
        .dat_s      (dat_s),
        .ptr_o      (ptr),
        .irq_en_o   (irq_en_o),
        .ler_o      (ler),
        .addr_eff_o (addr_eff),
        .addr_q_o   (addr_q)
    );

    nip_rdmux #(.NL(NLINES)) u_rdmux (
        .cs_s     (cs_s),
        .rd_s     (rd_s),
        .wr_s     (wr_s),
        .addr_eff (addr_eff),
        .ptr      (ptr),
        .hot      (hot_i),
        .lowv     (lowv_i),
        .open_l   (open_i),
        .ovld     (ovld_i),
        .swon     (swon_i),
        .therm    (therm_i),
        .ler      (ler),
        .dat_o    (dat_o),
        .dat_oe   (dat_oe)
    );

    assign line_en_o = ler;

endmodule

// File: rtl/nib_ind_port_chk.sv
module nib_ind_port_chk #(
    parameter int NL = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_s,
    input logic          rd_s,
    input logic          wr_s,
    input logic          ale_s,
    input logic          addr_q,
    input logic [NL-1:0] dat_o,
    input logic          dat_oe,
    input logic [NL-1:0] line_en,
    input logic          irq_en
);

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1: state is clear in the first cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        rst_seen |-> (line_en == '0 && !irq_en && !dat_oe));

    // R2: the address latch holds while the synchronised ale is low
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        $past(!ale_s) |-> $stable(addr_q));

    // R4: the flag bit changes only after a write has been released
    a_r4_irq_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq_en) |-> ($past(cs_s) || $past(wr_s)));

    // R9: the bus is driven only with chip select active
    a_r9_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
        dat_oe |-> !cs_s);

    // R9: an undriven bus carries zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !dat_oe |-> dat_o == '0);

    // R10: the line-enable word changes only after a write has been released
    a_r10_ler_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_en) |-> ($past(cs_s) || $past(wr_s)));

    // R11: both strobes low never drives the bus
    a_r11_no_dual: assert property (@(posedge clk) disable iff (rst)
        (!rd_s && !wr_s) |-> !dat_oe);

endmodule

bind nib_ind_port nib_ind_port_chk #(.NL(NLINES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (cs_s),
    .rd_s    (rd_s),
    .wr_s    (wr_s),
    .ale_s   (ale_s),
    .addr_q  (addr_q),
    .dat_o   (dat_o),
    .dat_oe  (dat_oe),
    .line_en (line_en_o),
    .irq_en  (irq_en_o)
);

// File: tb/nib_ind_port_tb.sv
module nib_ind_port_tb;

    localparam int NL = 4;
    localparam int SY = 2;
    localparam logic [8:0] IDLE = 9'b111_00_0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0, a0 = 1'b0;
    logic [NL-1:0] dat_i = '0;
    logic [NL-1:0] dat_o;
    logic          dat_oe;
    logic [NL-1:0] lowv_i = '0, open_i = '0, ovld_i = '0, swon_i = '0, therm_i = '0;
    logic          hot_i = 1'b0;
    logic [NL-1:0] line_en_o;
    logic          irq_en_o;

    nib_ind_port #(.NLINES(NL), .SYNC_STAGES(SY)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .ale(ale), .a0(a0), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe),
        .lowv_i(lowv_i), .open_i(open_i), .ovld_i(ovld_i), .swon_i(swon_i),
        .therm_i(therm_i), .hot_i(hot_i), .line_en_o(line_en_o), .irq_en_o(irq_en_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit started = 0;

    // Behavioural reference: pin history queue plus the visible register values.
    logic [8:0]  hist[$];
    logic        m_addr, m_ien, m_pend, m_padr;
    logic [2:0]  m_ptr;
    logic [3:0]  m_ler, m_pdat;

    function automatic logic [3:0] grp(input logic [2:0] p);
        case (p)
            3'd0: return lowv_i;
            3'd1: return open_i;
            3'd2: return ovld_i;
            3'd3: return swon_i;
            3'd6: return m_ler;
            3'd7: return therm_i;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    always @(posedge clk) begin : model_step
        logic [8:0] v;
        logic       ea, wn;
        started = 1;
        if (rst) begin
            m_addr = 0; m_ien = 0; m_pend = 0; m_padr = 0;
            m_ptr = 0; m_ler = 0; m_pdat = 0;
            hist = {};
            for (int i = 0; i < SY; i++) hist.push_back(IDLE);
        end else begin
            v  = hist[SY-1];
            ea = v[5] ? v[4] : m_addr;
            if (v[5]) m_addr = v[4];
            wn = !v[8] && !v[6] && v[7];
            if (m_pend && !wn) begin
                if (m_padr) m_ler = m_pdat;
                else begin m_ptr = m_pdat[2:0]; m_ien = m_pdat[3]; end
            end
            m_pend = wn;
            if (wn) begin m_padr = ea; m_pdat = v[3:0]; end
            hist.push_front({cs_n, rd_n, wr_n, ale, a0, dat_i});
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin : model_cmp
        logic [8:0] v;
        logic       ea, rok;
        logic [3:0] ed;
        if (started) begin
            v   = hist[SY-1];
            ea  = v[5] ? v[4] : m_addr;
            rok = !v[8] && !v[7] && v[6];
            ed  = !rok ? 4'b0000 : (ea ? grp(m_ptr) : {hot_i, m_ptr});
            chk(rst ? "R1 oe" : "R9 oe", {3'b000, dat_oe}, {3'b000, rok});
            chk(!rok ? "R9 idle data" : (!ea ? "R5 direct read" :
                ((m_ptr == 3'd4 || m_ptr == 3'd5) ? "R8 reserved" : "R7 group read")),
                dat_o, ed);
            chk(rst ? "R1 line_en" : "R6 line_en", line_en_o, m_ler);
            chk(rst ? "R1 irq_en" : "R4 irq_en", {3'b000, irq_en_o}, {3'b000, m_ien});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // One host access. mux=1 pulses ale and then scrambles a0 (R2).
    task automatic xfer(input bit mux, input bit a, input bit is_wr, input bit cs_first,
                        input logic [3:0] d, output logic [3:0] rdat);
        ale = 1'b1; a0 = a;
        tick(3);
        if (mux) begin ale = 1'b0; tick(2); a0 = ~a; end
        dat_i = d;
        cs_n = 1'b0;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        tick(5);
        rdat = dat_o;
        if (cs_first) begin cs_n = 1'b1; tick(1); wr_n = 1'b1; rd_n = 1'b1; end
        else begin wr_n = 1'b1; rd_n = 1'b1; tick(1); cs_n = 1'b1; end
        tick(5);
    endtask

    function automatic logic [3:0] exp_grp(input int p);
        case (p)
            0: return 4'b1000;
            1: return 4'b0100;
            2: return 4'b0011;
            3: return 4'b1010;
            6: return 4'b0101;
            7: return 4'b0110;
            default: return 4'b0000;
        endcase
    endfunction

    initial begin
        logic [3:0] r;
        for (int i = 0; i < SY; i++) hist.push_back(IDLE);
        m_addr = 0; m_ien = 0; m_pend = 0; m_padr = 0; m_ptr = 0; m_ler = 0; m_pdat = 0;
        tick(4);
        rst = 1'b0;
        tick(1);
        chk("R1 reset line_en", line_en_o, 4'b0000);
        chk("R1 reset irq_en", {3'b000, irq_en_o}, 4'b0000);
        chk("R1 reset oe", {3'b000, dat_oe}, 4'b0000);

        // R4: direct write sets pointer 2 and the flag
        xfer(1, 0, 1, 0, 4'b1010, r);
        chk("R4 irq_en set", {3'b000, irq_en_o}, 4'b0001);
        // R6: address 1 write lands in line enable even though pointer is 2
        xfer(1, 1, 1, 0, 4'b0101, r);
        chk("R6 line_en", line_en_o, 4'b0101);

        lowv_i = 4'b1000; open_i = 4'b0100; ovld_i = 4'b0011;
        swon_i = 4'b1010; therm_i = 4'b0110; hot_i = 1'b1;

        // R7 / R8: every pointer code, multiplexed bus with scrambled a0 (R2)
        for (int p = 0; p < 8; p++) begin
            xfer(1, 0, 1, 0, {1'b1, 3'(p)}, r);
            xfer(1, 1, 0, 0, 4'b0000, r);
            chk((p == 4 || p == 5) ? "R8 reserved code" : "R7 group select", r, exp_grp(p));
        end

        // R5: direct read returns shutdown flag and pointer
        xfer(1, 0, 0, 0, 4'b0000, r);
        chk("R5 direct read hot", r, 4'b1111);
        hot_i = 1'b0;
        xfer(1, 0, 0, 1, 4'b0000, r);
        chk("R5 direct read cool", r, 4'b0111);

        // R3: ale tied high, write ended by chip select first (R10)
        xfer(0, 1, 1, 1, 4'b1100, r);
        chk("R3 line_en nonmux", line_en_o, 4'b1100);
        xfer(0, 1, 0, 0, 4'b0000, r);
        chk("R3 therm read nonmux", r, 4'b0110);
        xfer(0, 0, 1, 0, 4'b0110, r);
        chk("R4 irq_en cleared", {3'b000, irq_en_o}, 4'b0000);
        xfer(0, 1, 0, 0, 4'b0000, r);
        chk("R3 line_en readback", r, 4'b1100);

        // R12: bit 0 belongs to line 0
        lowv_i = 4'b0001;
        xfer(0, 0, 1, 0, 4'b0000, r);
        xfer(0, 1, 0, 0, 4'b0000, r);
        chk("R12 line0 at bit0", r, 4'b0001);

        // R11: all strobes low together
        ale = 1'b1; a0 = 1'b1; dat_i = 4'b1111;
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        tick(6);
        chk("R11 no drive", {3'b000, dat_oe}, 4'b0000);
        rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
        tick(5);
        chk("R11 no write", line_en_o, 4'b1100);

        // R9: read strobe with chip select high
        rd_n = 1'b0;
        tick(5);
        chk("R9 cs high oe", {3'b000, dat_oe}, 4'b0000);
        chk("R9 cs high data", dat_o, 4'b0000);
        rd_n = 1'b1;
        tick(3);

        // R9: drive latency of SYNC_STAGES edges
        cs_n = 1'b0; rd_n = 1'b0;
        tick(1);
        chk("R9 oe after one edge", {3'b000, dat_oe}, 4'b0000);
        tick(1);
        chk("R9 oe after two edges", {3'b000, dat_oe}, 4'b0001);
        rd_n = 1'b1; cs_n = 1'b1;
        tick(4);

        // R10: commit on the third edge after the write strobe rises
        dat_i = 4'b0011; cs_n = 1'b0; wr_n = 1'b0;
        tick(5);
        wr_n = 1'b1;
        dat_i = 4'b1001;
        tick(2);
        chk("R10 not yet committed", line_en_o, 4'b1100);
        tick(1);
        chk("R10 committed", line_en_o, 4'b0011);
        cs_n = 1'b1;
        tick(4);

        // R1: reset during operation
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        chk("R1 mid-run reset", line_en_o, 4'b0000);
        tick(3);

        summary();
        $finish;
    end

endmodule